// File: doc/BRIEF.md
# Reciprocal Estimate Unit for Double-Precision Operands

The unit accepts one 64-bit IEEE-754 double-precision operand and returns a reciprocal estimate, also as a double. The estimate is bit-exact and deterministic. It is not a true division. The unit first sorts the operand into a class: zero, infinity, NaN, too small, too large, or ordinary. For an ordinary operand it forms the result exponent by subtracting the input's biased exponent from a constant. It builds the result fraction by linear interpolation between points held in two fixed 32-entry tables: one gives a starting value, the other gives a slope per step.

A caller presents the operand with `in_valid` high. Exactly one clock later the registered estimate appears with `out_valid`. A flag marks a division by zero in the same cycle. The estimate is meant as the seed for software or hardware refinement. Trap handling and status reporting belong to the surrounding logic.

Top module: `recip_est_unit`

## Requirements
- R1: `out_valid` equals the value `in_valid` had one clock earlier. A synchronous active-low reset (`rst_n` = 0) clears `out_valid`, `out_val` and `out_dz`.
- R2: An operand with biased exponent 0 and fraction 0 yields infinity with the operand's sign (exponent 0x7FF, fraction 0). `out_dz` is raised in that output cycle.
- R3: An operand with exponent 0x7FF and fraction 0 (infinity) yields zero with the operand's sign.
- R4: An operand with exponent 0x7FF and a nonzero fraction (NaN) is returned unchanged, except that fraction bit 51 is forced to 1.
- R5: A nonzero operand with biased exponent below 895 yields the largest finite single-precision magnitude as a double (0x47EFFFFFE0000000) with the operand's sign. This class includes subnormals.
- R6: A finite operand with biased exponent 1149 or more yields zero with the operand's sign.
- R7: An ordinary operand (biased exponent 895 to 1148) yields a result with the operand's sign and biased exponent 0x7FD minus the operand's exponent.
- R8: For an ordinary operand, let idx be fraction bits 51..47 and step be bits 46..37. The result fraction bits 51..29 hold base[idx] − floor((slope[idx]·step + 1)/2), and bits 28..0 are zero. Fraction bits 36..0 of the operand have no effect.
- R9: `out_dz` is 1 only in an output cycle whose operand was zero. It is 0 for every other class and whenever `out_valid` is 0.
- R10: The classes are resolved in this order: zero, then infinity or NaN, then small exponent, then large exponent, then ordinary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand present |
| in_val | input | 64 | Operand, IEEE-754 double |
| out_valid | output | 1 | Estimate present (one cycle after in_valid) |
| out_val | output | 64 | Reciprocal estimate, IEEE-754 double |
| out_dz | output | 1 | Divide-by-zero flag for the current estimate |

## Verification
The hardest conditions to reach from the ports are the exponent thresholds: 894 against 895, and 1148 against 1149. Subnormals must fall into the saturation class and not be treated as zero. The bench drives operands sitting on each side of both thresholds, with both signs, alongside exact zeros and infinities. Every one of the 32768 values of fraction bits 51..37 is swept with varying exponents and with random low-order bits. This exercises the last step of every table segment and the segments whose slopes repeat. NaNs are sent both with the quiet bit already set and with it clear.

// File: rtl/recip_est_pkg.sv
// Package: shared widths, class thresholds, operand class type and the
// two interpolation tables (start value and per-step slope).
// Assumes IEEE-754 binary64 layout: sign 63, exponent 62..52, fraction 51..0.
package recip_est_pkg;
    parameter int DW       = 64;
    parameter int EXP_W    = 11;
    parameter int FRAC_W   = 52;
    parameter int IDX_W    = 5;
    parameter int STEP_W   = 10;
    parameter int SEED_W   = 23;
    parameter int SLOPE_W  = 10;
    localparam int KEY_W   = IDX_W + STEP_W;
    localparam int LOW_W   = FRAC_W - SEED_W;
    localparam int PROD_W  = SLOPE_W + STEP_W + 1;

    parameter logic [EXP_W-1:0] EXP_TINY_LIM = 11'd895;
    parameter logic [EXP_W-1:0] EXP_HUGE_LIM = 11'd1149;
    parameter logic [EXP_W-1:0] EXP_BIAS_SUM = 11'h7FD;
    parameter logic [DW-2:0]    SAT_MAG      = 63'h47EF_FFFF_E000_0000;

    typedef enum logic [2:0] {
        OPC_ZERO, OPC_INF, OPC_NAN, OPC_TINY, OPC_HUGE, OPC_NORM
    } opclass_t;

    // Start value of the interpolation segment selected by idx.
    function automatic logic [SEED_W-1:0] seg_start(input logic [IDX_W-1:0] idx);
        case (idx)
            5'd0:  seg_start = 23'h7FF800;  5'd1:  seg_start = 23'h783800;
            5'd2:  seg_start = 23'h70EA00;  5'd3:  seg_start = 23'h6A0800;
            5'd4:  seg_start = 23'h638800;  5'd5:  seg_start = 23'h5D6200;
            5'd6:  seg_start = 23'h579000;  5'd7:  seg_start = 23'h520800;
            5'd8:  seg_start = 23'h4CC800;  5'd9:  seg_start = 23'h47CA00;
            5'd10: seg_start = 23'h430800;  5'd11: seg_start = 23'h3E8000;
            5'd12: seg_start = 23'h3A2C00;  5'd13: seg_start = 23'h360800;
            5'd14: seg_start = 23'h321400;  5'd15: seg_start = 23'h2E4A00;
            5'd16: seg_start = 23'h2AA800;  5'd17: seg_start = 23'h272C00;
            5'd18: seg_start = 23'h23D600;  5'd19: seg_start = 23'h209E00;
            5'd20: seg_start = 23'h1D8800;  5'd21: seg_start = 23'h1A9000;
            5'd22: seg_start = 23'h17AE00;  5'd23: seg_start = 23'h14F800;
            5'd24: seg_start = 23'h124400;  5'd25: seg_start = 23'h0FBE00;
            5'd26: seg_start = 23'h0D3800;  5'd27: seg_start = 23'h0ADE00;
            5'd28: seg_start = 23'h088400;  5'd29: seg_start = 23'h065000;
            5'd30: seg_start = 23'h041C00;  default: seg_start = 23'h020C00;
        endcase
    endfunction

    // Per-step slope of the interpolation segment selected by idx.
    function automatic logic [SLOPE_W-1:0] seg_slope(input logic [IDX_W-1:0] idx);
        case (idx)
            5'd0:  seg_slope = 10'h3E1;  5'd1:  seg_slope = 10'h3A7;
            5'd2:  seg_slope = 10'h371;  5'd3:  seg_slope = 10'h340;
            5'd4:  seg_slope = 10'h313;  5'd5:  seg_slope = 10'h2EA;
            5'd6:  seg_slope = 10'h2C4;  5'd7:  seg_slope = 10'h2A0;
            5'd8:  seg_slope = 10'h27F;  5'd9:  seg_slope = 10'h261;
            5'd10: seg_slope = 10'h245;  5'd11: seg_slope = 10'h22A;
            5'd12: seg_slope = 10'h212;  5'd13: seg_slope = 10'h1FB;
            5'd14: seg_slope = 10'h1E5;  5'd15: seg_slope = 10'h1D1;
            5'd16: seg_slope = 10'h1BE;  5'd17: seg_slope = 10'h1AC;
            5'd18: seg_slope = 10'h19B;  5'd19: seg_slope = 10'h18B;
            5'd20: seg_slope = 10'h17C;  5'd21: seg_slope = 10'h16E;
            5'd22: seg_slope = 10'h15B;  5'd23: seg_slope = 10'h15B;
            5'd24: seg_slope = 10'h143;  5'd25: seg_slope = 10'h143;
            5'd26: seg_slope = 10'h12D;  5'd27: seg_slope = 10'h12D;
            5'd28: seg_slope = 10'h11A;  5'd29: seg_slope = 10'h11A;
            5'd30: seg_slope = 10'h108;  default: seg_slope = 10'h106;
        endcase
    endfunction
endpackage

// File: rtl/recip_est_classify.sv
// Module: recip_est_classify
// Sorts a double-precision operand into one class, resolving overlaps in
// fixed priority: zero, infinity/NaN, small exponent, large exponent, ordinary.
// Assumes: purely combinational; fields taken from the standard binary64 layout.
module recip_est_classify
    import recip_est_pkg::*;
(
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W-1:0] frac_i,
    output opclass_t          cls_o
);
    logic exp_zero, exp_ones, frac_zero;

    // Field predicates.
    always_comb begin
        exp_zero  = (exp_i == '0);
        exp_ones  = (exp_i == '1);
        frac_zero = (frac_i == '0);
    end

    // Priority resolution of the operand class.
    always_comb begin
        if (exp_zero && frac_zero)       cls_o = OPC_ZERO;
        else if (exp_ones && frac_zero)  cls_o = OPC_INF;
        else if (exp_ones)               cls_o = OPC_NAN;
        else if (exp_i < EXP_TINY_LIM)   cls_o = OPC_TINY;
        else if (exp_i >= EXP_HUGE_LIM)  cls_o = OPC_HUGE;
        else                             cls_o = OPC_NORM;
    end
endmodule

// File: rtl/recip_est_interp.sv
// Module: recip_est_interp
// Builds the estimate's upper fraction bits by linear interpolation:
// start[idx] - floor((slope[idx]*step + 1)/2).
// Assumes: key_i is fraction bits 51..37, with idx in the top IDX_W bits;
// the tables never let the result go negative.
module recip_est_interp
    import recip_est_pkg::*;
(
    input  logic [KEY_W-1:0]  key_i,
    output logic [SEED_W-1:0] seed_o
);
    logic [IDX_W-1:0]   idx;
    logic [STEP_W-1:0]  step;
    logic [PROD_W-1:0]  prod;
    logic [PROD_W-1:0]  half;

    // Split the key into segment index and step count.
    always_comb begin
        idx  = key_i[KEY_W-1 -: IDX_W];
        step = key_i[STEP_W-1:0];
    end

    // Rounded half-product, subtracted from the segment start value.
    always_comb begin
        prod   = PROD_W'(seg_slope(idx)) * PROD_W'(step) + PROD_W'(1);
        half   = prod >> 1;
        seed_o = seg_start(idx) - SEED_W'(half);
    end
endmodule

// File: rtl/recip_est_unit.sv
// Module: recip_est_unit (top)
// Reciprocal estimate of a binary64 operand with one output register stage.
// Assumes: synchronous active-low reset; an operand is accepted in every
// cycle where in_valid is high, with no back-pressure.
module recip_est_unit
    import recip_est_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_val,
    output logic          out_valid,
    output logic [DW-1:0] out_val,
    output logic          out_dz
);
    logic              sgn;
    logic [EXP_W-1:0]  exp_in;
    logic [FRAC_W-1:0] frac_in;
    opclass_t          cls;
    logic [SEED_W-1:0] seed;
    logic [EXP_W-1:0]  exp_res;
    logic [DW-1:0]     res_d;

    // Field extraction from the operand.
    always_comb begin
        sgn     = in_val[DW-1];
        exp_in  = in_val[DW-2 -: EXP_W];
        frac_in = in_val[FRAC_W-1:0];
    end

    recip_est_classify u_cls (
        .exp_i  (exp_in),
        .frac_i (frac_in),
        .cls_o  (cls)
    );

    recip_est_interp u_interp (
        .key_i  (frac_in[FRAC_W-1 -: KEY_W]),
        .seed_o (seed)
    );

    // Result selection per operand class.
    always_comb begin
        exp_res = EXP_BIAS_SUM - exp_in;
        case (cls)
            OPC_ZERO: res_d = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            OPC_INF:  res_d = {sgn, {(DW-1){1'b0}}};
            OPC_NAN:  res_d = in_val | (DW'(1) << (FRAC_W-1));
            OPC_TINY: res_d = {sgn, SAT_MAG};
            OPC_HUGE: res_d = {sgn, {(DW-1){1'b0}}};
            default:  res_d = {sgn, exp_res, seed, {LOW_W{1'b0}}};
        endcase
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_val   <= '0;
            out_dz    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_val <= res_d;
                out_dz  <= (cls == OPC_ZERO);
            end else begin
                out_dz  <= 1'b0;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid)); // R1
    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_val[DW-1] == $past(in_val[DW-1])); // R7
    AST_DZ_IS_INF: assert property (@(posedge clk) disable iff (!rst_n)
        out_dz |-> (out_val[DW-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}})); // R2
    AST_DZ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        out_dz |-> out_valid); // R9
    AST_DZ_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
        out_dz |-> $past(in_val[DW-2:0]) == '0); // R9
endmodule

// File: tb/recip_est_unit_tb.sv
`timescale 1ns/1ps
module recip_est_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_val = '0;
    logic        out_valid;
    logic [63:0] out_val;
    logic        out_dz;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int unsigned ref_start [32] = '{
        'h7FF800,'h783800,'h70EA00,'h6A0800,'h638800,'h5D6200,'h579000,'h520800,
        'h4CC800,'h47CA00,'h430800,'h3E8000,'h3A2C00,'h360800,'h321400,'h2E4A00,
        'h2AA800,'h272C00,'h23D600,'h209E00,'h1D8800,'h1A9000,'h17AE00,'h14F800,
        'h124400,'h0FBE00,'h0D3800,'h0ADE00,'h088400,'h065000,'h041C00,'h020C00};
    int unsigned ref_slope [32] = '{
        'h3E1,'h3A7,'h371,'h340,'h313,'h2EA,'h2C4,'h2A0,
        'h27F,'h261,'h245,'h22A,'h212,'h1FB,'h1E5,'h1D1,
        'h1BE,'h1AC,'h19B,'h18B,'h17C,'h16E,'h15B,'h15B,
        'h143,'h143,'h12D,'h12D,'h11A,'h11A,'h108,'h106};

    always #2.5 clk = ~clk;

    recip_est_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_val(in_val),
        .out_valid(out_valid), .out_val(out_val), .out_dz(out_dz)
    );

    function automatic logic [63:0] model(input logic [63:0] x);
        logic s; logic [10:0] e; logic [51:0] f; int unsigned i, st, v;
        s = x[63]; e = x[62:52]; f = x[51:0];
        if (e == 0 && f == 0) return {s, 11'h7FF, 52'h0};
        if (e == 11'h7FF) return (f == 0) ? {s, 63'h0} : (x | (64'h1 << 51));
        if (e < 895) return {s, 63'h47EF_FFFF_E000_0000};
        if (e >= 1149) return {s, 63'h0};
        i = f[51:47]; st = f[46:37];
        v = ref_start[i] - (ref_slope[i] * st + 1) / 2;
        return {s, 11'(2045 - e), v[22:0], 29'h0};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input string req, input logic [63:0] x);
        logic [63:0] e;
        e = model(x);
        @(negedge clk); in_valid = 1'b1; in_val = x;
        @(negedge clk);
        check({req, " value"}, out_val, e);
        check("R1 valid", {63'h0, out_valid}, 64'h1);
        check("R9 dz", {63'h0, out_dz},
              {63'h0, (x[62:0] == 63'h0)});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", {63'h0, out_valid}, 64'h0);
        check("R1 reset val", out_val, 64'h0);
        check("R9 reset dz", {63'h0, out_dz}, 64'h0);
        rst_n = 1'b1;
        // R2 zero, R10 priority over the small-exponent class
        apply("R2", 64'h0);
        apply("R2", 64'h8000_0000_0000_0000);
        apply("R3", 64'h7FF0_0000_0000_0000);
        apply("R3", 64'hFFF0_0000_0000_0000);
        apply("R4", 64'h7FF0_0000_0000_0001);
        apply("R4", 64'hFFF8_1234_5678_9ABC);
        apply("R4", 64'h7FF4_0000_0000_0000);
        apply("R5", 64'h0000_0000_0000_0001);
        apply("R5", 64'h800F_FFFF_FFFF_FFFF);
        apply("R5", {1'b0, 11'd894, 52'hF_FFFF_FFFF_FFFF});
        apply("R7", {1'b1, 11'd895, 52'h0});
        apply("R7", {1'b0, 11'd1148, 52'hF_FFFF_FFFF_FFFF});
        apply("R6", {1'b0, 11'd1149, 52'h0});
        apply("R6", {1'b1, 11'd2046, 52'h8_0000_0000_0000});
        apply("R8", {1'b0, 11'd1023, 52'h0});
        apply("R8", {1'b0, 11'd1023, 15'h7FFF, 37'h0});
        // R8 low bits ignored: same key, different low fraction bits
        apply("R8", {1'b0, 11'd1000, 15'h1234, 37'h1F_FFFF_FFFF});
        apply("R8", {1'b0, 11'd1000, 15'h1234, 37'h0});
        // R1 valid drops one cycle after in_valid drops
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        check("R1 idle valid", {63'h0, out_valid}, 64'h0);
        check("R9 idle dz", {63'h0, out_dz}, 64'h0);
        // R8 R7 sweep of every key with varying exponent and sign
        for (int k = 0; k < 32768; k++) begin
            logic [63:0] x;
            x = {k[0], 11'(895 + (k * 37) % 254), 15'(k), 37'($urandom) };
            apply("R8", x);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule